// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port Pair

This block puts two identical parallel-port peripherals on a CPU bus. Each peripheral owns two 8-bit ports, called A and B. Every pin can be an input or an output, and each pin is set on its own. Software sets a pin's direction, drives the output value and reads the pin level through a small register file. The register file has 16 slots and is selected by the low four address bits.

A page decoder compares the upper address byte with a base page. Instance 0 answers on page 0xDC and instance 1 on page 0xDD, and only while the system-level active-low select input is low. Address bits 7 to 4 are not decoded, so the 16 registers repeat sixteen times across each 256-byte page.

On the pin side, each bit has an output value and an output enable. It also has an external value and an external-drive flag. A pin that is an input and is not driven from outside reads as 1, which models a weak pull-up. Input levels pass through a two-flop synchronizer before software can read them.

Top module: `pio_dual`

## Requirements
- R1: After a synchronous reset (rstN low at a rising clock edge), every data register and every direction register is 0. All output enables and output values are therefore 0.
- R2: Register offset 0 is port A data, offset 1 is port B data, offset 2 is port A direction and offset 3 is port B direction. A write takes effect at the rising edge where busWr is sampled high, and shows on the pin outputs after that edge. Only a write to offset 2 or 3 changes an output enable.
- R3: Direction bit 1 makes that pin an output (its enable is 1) and bit 0 makes it an input. The bits are independent, so any mix of inputs and outputs is allowed on one port.
- R4: Reading a data register returns, for each bit, the data register bit when that bit is an output, and the synchronized pin level when that bit is an input.
- R5: An input bit whose external-drive flag is 0 reads as 1 (pull-up). An input bit whose flag is 1 reads the external value.
- R6: A change on an external input is visible to reads only after two rising clock edges. After a single edge the old level is still read.
- R7: Instance 0 is selected when address bits 15 to 8 equal 0xDC, and instance 1 when they equal 0xDD. Any other page neither writes anything, and a read there returns 0x00. Instance i uses pin bits [8i+7 : 8i] of each flattened pin bus.
- R8: While busSelN is high, nothing is written and busRdData is 0x00. busRdData is also 0x00 whenever busRd is low.
- R9: Address bits 7 to 4 are ignored, so all 16 mirror addresses of a register reach the same register.
- R10: Offsets 4 to 15 read as 0x00. Writes to them change no register or pin.
- R11: Reading offset 2 or 3 returns the direction register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSelN | input | 1 | Active-low select for the whole I/O area |
| busAddr | input | 16 | Bus address; page in [15:8], register in [3:0] |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busRd | input | 1 | Read strobe; read data is combinational |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, 0 when no instance is read |
| paOut | output | 16 | Port A output values, 8 bits per instance |
| paOe | output | 16 | Port A output enables |
| paExtVal | input | 16 | Port A level driven by outside circuitry |
| paExtDrv | input | 16 | Port A per-bit flag: outside circuitry drives the pin |
| pbOut | output | 16 | Port B output values |
| pbOe | output | 16 | Port B output enables |
| pbExtVal | input | 16 | Port B level driven by outside circuitry |
| pbExtDrv | input | 16 | Port B per-bit flag: outside circuitry drives the pin |

## Verification
The assertions assume that busWr and busRd are never high together. They also assume that nothing on the bus is meaningful before the first reset edge. The stimulus raises one strobe at a time, changes bus signals only at falling edges, and holds rstN low for several cycles at the start. The pin-side inputs are changed only at falling edges. The sweep of direction values leaves the external pins steady long enough for the synchronizer to settle, except in the test that checks the synchronizer's latency.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Register offsets within one instance; software depends on these.
  localparam int unsigned REG_DATA_A = 0;
  localparam int unsigned REG_DATA_B = 1;
  localparam int unsigned REG_DIR_A  = 2;
  localparam int unsigned REG_DIR_B  = 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DATA_A,
    RD_DATA_B,
    RD_DIR_A,
    RD_DIR_B
  } rdSel_e;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic   wrDataA;
    logic   wrDataB;
    logic   wrDirA;
    logic   wrDirB;
    rdSel_e rdSel;
  } pioStrobe_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              ceN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [REG_AW-1:0] regAddr,
  output pioStrobe_t        strobe
);

  logic wrEn;
  logic rdEn;

  assign wrEn = !ceN && busWr;
  assign rdEn = !ceN && busRd;

  always_comb begin
    strobe = '{wrDataA: 1'b0, wrDataB: 1'b0, wrDirA: 1'b0, wrDirB: 1'b0, rdSel: RD_NONE};
    if (regAddr == REG_AW'(REG_DATA_A)) begin
      strobe.wrDataA = wrEn;
      if (rdEn) strobe.rdSel = RD_DATA_A;
    end else if (regAddr == REG_AW'(REG_DATA_B)) begin
      strobe.wrDataB = wrEn;
      if (rdEn) strobe.rdSel = RD_DATA_B;
    end else if (regAddr == REG_AW'(REG_DIR_A)) begin
      strobe.wrDirA = wrEn;
      if (rdEn) strobe.rdSel = RD_DIR_A;
    end else if (regAddr == REG_AW'(REG_DIR_B)) begin
      strobe.wrDirB = wrEn;
      if (rdEn) strobe.rdSel = RD_DIR_B;
    end
    // Offsets 4 and above: no strobe, so the read falls through to RD_NONE (zero).
  end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  // Reset to all ones: the idle, pulled-up pin level.
  always_ff @(posedge clk) begin
    if (!rstN) stageQ[0] <= '1;
    else       stageQ[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageQ[s] <= '1;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extValA,
  input  logic [DATA_W-1:0] extDrvA,
  input  logic [DATA_W-1:0] extValB,
  input  logic [DATA_W-1:0] extDrvB,
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] oeA,
  output logic [DATA_W-1:0] outB,
  output logic [DATA_W-1:0] oeB,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] dataAQ, dataBQ, dirAQ, dirBQ;
  logic [DATA_W-1:0] padA, padB;
  logic [DATA_W-1:0] syncA, syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataAQ <= '0;
      dataBQ <= '0;
      dirAQ  <= '0;
      dirBQ  <= '0;
    end else begin
      if (strobe.wrDataA) dataAQ <= wrData;
      if (strobe.wrDataB) dataBQ <= wrData;
      if (strobe.wrDirA)  dirAQ  <= wrData;
      if (strobe.wrDirB)  dirBQ  <= wrData;
    end
  end

  // An undriven pin floats high through the weak pull-up.
  assign padA = (extValA & extDrvA) | ~extDrvA;
  assign padB = (extValB & extDrvB) | ~extDrvB;

  pio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_syncA (
    .clk (clk), .rstN(rstN), .din(padA), .dout(syncA)
  );
  pio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_syncB (
    .clk (clk), .rstN(rstN), .din(padB), .dout(syncB)
  );

  assign outA = dataAQ;
  assign oeA  = dirAQ;
  assign outB = dataBQ;
  assign oeB  = dirBQ;

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA_A: rdData = (dataAQ & dirAQ) | (syncA & ~dirAQ);
      RD_DATA_B: rdData = (dataBQ & dirBQ) | (syncB & ~dirBQ);
      RD_DIR_A:  rdData = dirAQ;
      RD_DIR_B:  rdData = dirBQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/pio_dual.sv
module pio_dual
  import pio_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 4,
  parameter int PAGE_LSB    = 8,
  parameter int NUM_INST    = 2,
  parameter int BASE_PAGE   = 'hDC,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSelN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic [DATA_W-1:0]          busWrData,
  output logic [DATA_W-1:0]          busRdData,
  output logic [NUM_INST*DATA_W-1:0] paOut,
  output logic [NUM_INST*DATA_W-1:0] paOe,
  input  logic [NUM_INST*DATA_W-1:0] paExtVal,
  input  logic [NUM_INST*DATA_W-1:0] paExtDrv,
  output logic [NUM_INST*DATA_W-1:0] pbOut,
  output logic [NUM_INST*DATA_W-1:0] pbOe,
  input  logic [NUM_INST*DATA_W-1:0] pbExtVal,
  input  logic [NUM_INST*DATA_W-1:0] pbExtDrv
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page;
  logic [REG_AW-1:0] regAddr;
  logic [NUM_INST-1:0] ceN;
  logic [DATA_W-1:0] instRd [NUM_INST];

  assign page    = busAddr[ADDR_W-1:PAGE_LSB];
  assign regAddr = busAddr[REG_AW-1:0];   // bits between REG_AW and PAGE_LSB are not decoded

  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    pioStrobe_t strobe;

    assign ceN[i] = busSelN || (page != PAGE_W'(BASE_PAGE + i));

    pio_ctrl #(.REG_AW(REG_AW)) u_ctrl (
      .ceN    (ceN[i]),
      .busWr  (busWr),
      .busRd  (busRd),
      .regAddr(regAddr),
      .strobe (strobe)
    );

    pio_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .wrData (busWrData),
      .extValA(paExtVal[i*DATA_W +: DATA_W]),
      .extDrvA(paExtDrv[i*DATA_W +: DATA_W]),
      .extValB(pbExtVal[i*DATA_W +: DATA_W]),
      .extDrvB(pbExtDrv[i*DATA_W +: DATA_W]),
      .outA   (paOut[i*DATA_W +: DATA_W]),
      .oeA    (paOe[i*DATA_W +: DATA_W]),
      .outB   (pbOut[i*DATA_W +: DATA_W]),
      .oeB    (pbOe[i*DATA_W +: DATA_W]),
      .rdData (instRd[i])
    );
  end

  // Unselected instances return zero, so an OR merges them.
  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_INST; i++) busRdData = busRdData | instRd[i];
  end

endmodule

// File: rtl/pio_dual_chk.sv
module pio_dual_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_AW    = 4,
  parameter int PAGE_LSB  = 8,
  parameter int NUM_INST  = 2,
  parameter int BASE_PAGE = 'hDC
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busSelN,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       busWr,
  input logic                       busRd,
  input logic [DATA_W-1:0]          busRdData,
  input logic [NUM_INST*DATA_W-1:0] paOut,
  input logic [NUM_INST*DATA_W-1:0] paOe,
  input logic [NUM_INST*DATA_W-1:0] pbOut,
  input logic [NUM_INST*DATA_W-1:0] pbOe
);

  logic pageHit;
  logic dirWrite;
  logic [REG_AW-1:0] regOff;

  assign regOff   = busAddr[REG_AW-1:0];
  assign pageHit  = (int'(busAddr[ADDR_W-1:PAGE_LSB]) >= BASE_PAGE) &&
                    (int'(busAddr[ADDR_W-1:PAGE_LSB]) <  BASE_PAGE + NUM_INST);
  assign dirWrite = busWr && !busSelN && pageHit &&
                    (regOff == REG_AW'(2) || regOff == REG_AW'(3));

  // R2: output enables move only on a direction-register write
  p_oe_by_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dirWrite |=> ($stable(paOe) && $stable(pbOe)));

  // R7: a page outside the decoded range writes nothing and reads zero
  p_page_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pageHit |=> ($stable(paOut) && $stable(pbOut) && $stable(paOe) && $stable(pbOe)));

  p_page_miss_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pageHit |-> (busRdData == '0));

  // R8: deselected bus writes nothing
  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    busSelN |=> ($stable(paOut) && $stable(pbOut) && $stable(paOe) && $stable(pbOe)));

  // R8: no read data without a selected read
  p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSelN || !busRd) |-> (busRdData == '0));

  // R10: unimplemented offsets read as zero
  p_high_reg_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regOff >= REG_AW'(4)) |-> (busRdData == '0));

endmodule

bind pio_dual pio_dual_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .PAGE_LSB(PAGE_LSB),
  .NUM_INST(NUM_INST), .BASE_PAGE(BASE_PAGE)
) u_chk (
  .clk(clk), .rstN(rstN), .busSelN(busSelN), .busAddr(busAddr),
  .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
  .paOut(paOut), .paOe(paOe), .pbOut(pbOut), .pbOe(pbOe)
);

// File: tb/pio_dual_test.sv
module pio_dual_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSelN = 1'b1;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] paOut, paOe, pbOut, pbOe;
  logic [15:0] paExtVal = '0, paExtDrv = '0, pbExtVal = '0, pbExtDrv = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pio_dual uut (
    .clk(clk), .rstN(rstN), .busSelN(busSelN), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData),
    .paOut(paOut), .paOe(paOe), .paExtVal(paExtVal), .paExtDrv(paExtDrv),
    .pbOut(pbOut), .pbOe(pbOe), .pbExtVal(pbExtVal), .pbExtDrv(pbExtDrv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1; busSelN = !sel;
    @(negedge clk);
    busWr = 1'b0; busSelN = 1'b1;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    busAddr = a; busRd = 1'b1; busSelN = !sel;
    #1;
    d = busRdData;
    busRd = 1'b0; busSelN = 1'b1;
  endtask

  function automatic logic [15:0] addrOf(input int inst, input int mir, input int off);
    return {8'(8'hDC + inst), 4'(mir), 4'(off)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] pins;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    chk("R1 paOe", 32'(paOe), 0);
    chk("R1 pbOe", 32'(pbOe), 0);
    chk("R1 paOut", 32'(paOut), 0);
    chk("R1 pbOut", 32'(pbOut), 0);
    for (int i = 0; i < 2; i++) begin
      busRead(addrOf(i, 0, 2), rd); chk("R1 R11 dirA reset", 32'(rd), 0);
      busRead(addrOf(i, 0, 3), rd); chk("R1 R11 dirB reset", 32'(rd), 0);
      busRead(addrOf(i, 0, 0), rd); chk("R1 R5 dataA floating", 32'(rd), 32'hFF);
    end

    // R2 R3 R11 R9: registers through mirrored addresses, both instances
    for (int i = 0; i < 2; i++) begin
      for (int m = 0; m < 16; m++) begin
        logic [7:0] va, vb, dA, dB;
        va = 8'(m * 37 + i * 11 + 5); vb = ~va;
        dA = 8'(m * 53 + 3); dB = 8'(m * 29 + i);
        busWrite(addrOf(i, m, 2), va);
        busWrite(addrOf(i, m, 3), vb);
        busWrite(addrOf(i, m, 0), dA);
        busWrite(addrOf(i, m, 1), dB);
        chk("R2 R3 paOe", 32'(paOe[i*8 +: 8]), 32'(va));
        chk("R2 R3 pbOe", 32'(pbOe[i*8 +: 8]), 32'(vb));
        chk("R2 paOut", 32'(paOut[i*8 +: 8]), 32'(dA));
        chk("R2 pbOut", 32'(pbOut[i*8 +: 8]), 32'(dB));
        busRead(addrOf(i, 15 - m, 2), rd); chk("R9 R11 dirA mirror", 32'(rd), 32'(va));
        busRead(addrOf(i, (m + 7) % 16, 3), rd); chk("R9 R11 dirB mirror", 32'(rd), 32'(vb));
      end
    end

    // R7: instance independence (inst1 holds its last values)
    busWrite(addrOf(0, 0, 2), 8'h3C);
    chk("R7 inst1 untouched", 32'(paOe[15:8]), 32'(8'(15 * 37 + 11 + 5)));
    chk("R7 inst0 written", 32'(paOe[7:0]), 32'h3C);

    // R10: high offsets
    for (int off = 4; off < 16; off++) begin
      busWrite(addrOf(0, off, off), 8'hFF);
      busRead(addrOf(0, off, off), rd);
      chk("R10 high read", 32'(rd), 0);
    end
    chk("R10 oe unchanged", 32'(paOe[7:0]), 32'h3C);
    chk("R10 out unchanged", 32'(paOut[7:0]), 32'(8'(15 * 53 + 3)));

    // R4 R5: exhaustive direction sweep on port A, instance 0, and port B, instance 1
    @(negedge clk);
    paExtVal = 16'h0033; paExtDrv = 16'h000F;
    pbExtVal = 16'hC500; pbExtDrv = 16'hF000;
    busWrite(addrOf(0, 0, 0), 8'h5A);
    busWrite(addrOf(1, 0, 1), 8'hA9);
    for (int d = 0; d < 256; d++) begin
      busWrite(addrOf(0, 0, 2), 8'(d));
      busWrite(addrOf(1, 0, 3), 8'(d));
      pins = (8'h33 & 8'h0F) | ~8'h0F;
      busRead(addrOf(0, 0, 0), rd);
      chk("R4 R5 portA mix", 32'(rd), 32'((8'h5A & 8'(d)) | (pins & ~8'(d))));
      pins = (8'hC5 & 8'hF0) | ~8'hF0;
      busRead(addrOf(1, 0, 1), rd);
      chk("R4 R5 portB mix", 32'(rd), 32'((8'hA9 & 8'(d)) | (pins & ~8'(d))));
    end

    // R6: two-edge synchronizer latency on port A instance 0, all inputs
    busWrite(addrOf(0, 0, 2), 8'h00);
    @(negedge clk);
    paExtDrv[7:0] = 8'hFF; paExtVal[7:0] = 8'h00;
    repeat (3) @(negedge clk);
    busRead(addrOf(0, 0, 0), rd); chk("R6 settled", 32'(rd), 0);
    paExtVal[7:0] = 8'h96;
    busRead(addrOf(0, 0, 0), rd); chk("R6 after one edge", 32'(rd), 0);
    busRead(addrOf(0, 0, 0), rd); chk("R6 after two edges", 32'(rd), 32'h96);
    paExtDrv[7:0] = 8'h00;
    repeat (3) @(negedge clk);
    busRead(addrOf(0, 0, 0), rd); chk("R5 released pull-up", 32'(rd), 32'hFF);

    // R7: pages outside the decoded pair
    busWrite(16'hDE02, 8'hAA);
    busWrite(16'hDB02, 8'hAA);
    chk("R7 miss no write inst0", 32'(paOe[7:0]), 0);
    busRead(16'hDE00, rd); chk("R7 miss read", 32'(rd), 0);
    busRead(16'h1C02, rd); chk("R7 miss read low page", 32'(rd), 0);

    // R8: deselected bus
    busWrite(addrOf(0, 0, 2), 8'h77, 1'b0);
    chk("R8 desel no write", 32'(paOe[7:0]), 0);
    busRead(addrOf(0, 0, 3), rd, 1'b0); chk("R8 desel read", 32'(rd), 0);

    // R1: reset again clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 re-reset oe", 32'({paOe, pbOe}), 0);
    chk("R1 re-reset out", 32'({paOut, pbOut}), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule